// File: doc/BRIEF.md
# SD Card Start-up Handshake Sequencer

This block steers a card through its power-up handshake while the card clock runs at the slow identification rate (400 kHz). It does not shift bits itself. It commands a separate command serializer and a separate response receiver through request/acknowledge handshakes. A one-cycle strobe, `sd_clk_tick`, marks each card clock period.

After `start`, the sequencer holds the command line idle for a configurable run of card clocks. It then sends the software-reset command, followed by the interface-condition command, which carries a check pattern. The card must echo that pattern. Next it loops on the application-command prefix followed by the operating-condition request, until the card reports power-up complete.

It adds two checks beyond the basic order of commands:

- It confirms that the echoed check pattern matches.
- It reissues the prefix command once if the card flags a CRC failure on the previous command.

Any fault ends the run. The fault is reported as a code that names the failing step.

Top module: `sdinit_seq`

## Requirements
- R1: After `start`, `preamble` stays high for exactly `IDLE_CLKS` ticks of `sd_clk_tick` (default 80, never below 74), and no command is requested while it is high.
- R2: The first command is index 0 with argument 0. No response is requested for it, and the next command follows its `cmd_done`.
- R3: The second command is index 8 with argument 0x1AA. If bits 7:0 of its response payload are not 0xAA, the run ends with error code 3.
- R4: Each operating-condition round sends index 55 with argument 0, then index 41 with argument `OP_ARG` (default 0x40FF8000). Index 41 is only ever sent directly after an index-55 command.
- R5: If the index-55 response has payload bit 23 set, index 55 is sent once more. A second flagged response in the same round does not cause another reissue, and the round proceeds to index 41.
- R6: An index-41 response with payload bit 31 set ends the run with `done`=1 and `err_code`=0. After `MAX_OP_TRIES` index-41 responses with bit 31 clear, the run ends with error code 7.
- R7: The `rsp_crc_ok` flag is ignored on index-41 responses.
- R8: A response that reports a fault ends the run with `error`=1 and one of these codes:

  | Failing command | Timeout or framing fault | `rsp_crc_ok`=0 |
  |---|---|---|
  | Index 8 | 1 | 2 |
  | Index 55 | 4 | 5 |
  | Index 41 | 6 | ignored (R7) |

- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_index` and `cmd_arg` stay unchanged.
- R10: After reset, all outputs are low or zero. `done`, `error` and `err_code` hold until the next `start`, which clears them and restarts the sequence from the idle-clock run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the sequencer is idle or finished |
| sd_clk_tick | input | 1 | One-cycle strobe per card clock period |
| preamble | output | 1 | High while the idle-clock run is being counted |
| done | output | 1 | Card reported ready |
| error | output | 1 | Run ended in a fault |
| err_code | output | 4 | Fault code (0 = none) |
| cmd_valid | output | 1 | Command request to the serializer |
| cmd_ready | input | 1 | Serializer accepts the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Serializer finished sending |
| rsp_req | output | 1 | Request for a response from the receiver |
| rsp_valid | input | 1 | Response result strobe |
| rsp_payload | input | 32 | 32-bit response payload |
| rsp_crc_ok | input | 1 | Response CRC matched |
| rsp_timeout | input | 1 | No response arrived in time |
| rsp_frame_err | input | 1 | Response framing was wrong |

## Verification
The bench's stand-in card is scripted per command index, so each run varies one thing from the nominal run.

- **Busy rounds:** runs with zero, two and unbounded busy replies to index 41 separate correct looping from a premature finish and from an endless loop.
- **Flagged prefix replies:** one or two flagged index-55 replies in a row show that the reissue happens exactly once.
- **Injected faults:** a wrong echo byte, and a timeout, framing or CRC fault on each responding command, confirm that every step reports its own code.
- **CRC on index 41:** a CRC fault there shows it is ignored rather than reported.
- **Ordering:** every run compares the full recorded command list and arguments, which exposes wrong order, a missing retry or a spurious retry.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

   typedef enum logic [1:0] {
      STP_RST = 2'd0,
      STP_IF  = 2'd1,
      STP_APP = 2'd2,
      STP_OP  = 2'd3
   } step_e;

   typedef enum logic [3:0] {
      ERR_NONE     = 4'd0,
      ERR_IF_RSP   = 4'd1,
      ERR_IF_CRC   = 4'd2,
      ERR_IF_ECHO  = 4'd3,
      ERR_APP_RSP  = 4'd4,
      ERR_APP_CRC  = 4'd5,
      ERR_OP_RSP   = 4'd6,
      ERR_OP_BUSY  = 4'd7
   } err_e;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_PRE   = 3'd1,
      S_ISSUE = 3'd2,
      S_SENT  = 3'd3,
      S_RSP   = 3'd4,
      S_OK    = 3'd5,
      S_ERR   = 3'd6
   } state_e;

   localparam int MIN_IDLE_CLKS = 74;
   localparam int BIT_CRC_FLAG  = 23;
   localparam int BIT_PWR_UP    = 31;

endpackage

// File: rtl/sdinit_counter.sv
module sdinit_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (clr)
         count <= '0;
      else if (inc && count != TOP)
         count <= count + 1'b1;
   end
endmodule

// File: rtl/sdinit_cmd_table.sv
module sdinit_cmd_table
   import sdinit_pkg::*;
#(
   parameter logic [7:0]  CHECK_BYTE = 8'hAA,
   parameter logic [31:0] OP_ARG     = 32'h40FF_8000
) (
   input  step_e       step,
   output logic [5:0]  index,
   output logic [31:0] arg
);
   localparam logic [31:0] IF_ARG = {20'h0, 4'h1, CHECK_BYTE};

   always_comb begin
      unique case (step)
         STP_RST: begin index = 6'd0;  arg = 32'h0;  end
         STP_IF:  begin index = 6'd8;  arg = IF_ARG; end
         STP_APP: begin index = 6'd55; arg = 32'h0;  end
         default: begin index = 6'd41; arg = OP_ARG; end
      endcase
   end
endmodule

// File: rtl/sdinit_rsp_check.sv
module sdinit_rsp_check
   import sdinit_pkg::*;
#(
   parameter logic [7:0] CHECK_BYTE   = 8'hAA,
   parameter bit         STRICT_ECHO  = 1'b0
) (
   input  step_e       step,
   input  logic [31:0] payload,
   input  logic        crc_ok,
   input  logic        timeout,
   input  logic        frame_err,
   output logic        fail,
   output err_e        fail_code,
   output logic        crc_flag,
   output logic        card_ready
);
   logic echo_ok;
   logic lost;

   generate
      if (STRICT_ECHO) begin : g_echo_full
         assign echo_ok = (payload[11:0] == {4'h1, CHECK_BYTE});
      end else begin : g_echo_byte
         assign echo_ok = (payload[7:0] == CHECK_BYTE);
      end
   endgenerate

   assign lost       = timeout | frame_err;
   assign crc_flag   = payload[BIT_CRC_FLAG];
   assign card_ready = payload[BIT_PWR_UP];

   always_comb begin
      fail      = 1'b0;
      fail_code = ERR_NONE;
      unique case (step)
         STP_IF: begin
            if (lost)          begin fail = 1'b1; fail_code = ERR_IF_RSP;  end
            else if (!crc_ok)  begin fail = 1'b1; fail_code = ERR_IF_CRC;  end
            else if (!echo_ok) begin fail = 1'b1; fail_code = ERR_IF_ECHO; end
         end
         STP_APP: begin
            if (lost)          begin fail = 1'b1; fail_code = ERR_APP_RSP; end
            else if (!crc_ok)  begin fail = 1'b1; fail_code = ERR_APP_CRC; end
         end
         STP_OP: begin
            if (lost)          begin fail = 1'b1; fail_code = ERR_OP_RSP;  end
         end
         default: begin
            fail      = 1'b0;
            fail_code = ERR_NONE;
         end
      endcase
   end
endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
   import sdinit_pkg::*;
#(
   parameter int          IDLE_CLKS    = 80,
   parameter int          MAX_OP_TRIES = 1000,
   parameter logic [7:0]  CHECK_BYTE   = 8'hAA,
   parameter logic [31:0] OP_ARG       = 32'h40FF_8000,
   parameter bit          STRICT_ECHO  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        sd_clk_tick,
   output logic        preamble,
   output logic        done,
   output logic        error,
   output logic [3:0]  err_code,
   output logic        cmd_valid,
   input  logic        cmd_ready,
   output logic [5:0]  cmd_index,
   output logic [31:0] cmd_arg,
   input  logic        cmd_done,
   output logic        rsp_req,
   input  logic        rsp_valid,
   input  logic [31:0] rsp_payload,
   input  logic        rsp_crc_ok,
   input  logic        rsp_timeout,
   input  logic        rsp_frame_err
);
   localparam int PRE_W = $clog2(IDLE_CLKS + 2);
   localparam int TRY_W = $clog2(MAX_OP_TRIES + 1);
   localparam logic [PRE_W-1:0] PRE_END = PRE_W'(IDLE_CLKS);
   localparam logic [TRY_W-1:0] OP_LAST = TRY_W'(MAX_OP_TRIES - 1);

   generate
      if (IDLE_CLKS < MIN_IDLE_CLKS) begin : g_bad_idle
         $error("IDLE_CLKS below the 74-clock minimum");
      end
      if (MAX_OP_TRIES < 1) begin : g_bad_tries
         $error("MAX_OP_TRIES must be at least 1");
      end
   endgenerate

   state_e state;
   step_e  step;
   err_e   err_q;
   logic   app_retried;

   logic   can_start;
   logic   pre_done;
   logic   op_last;
   logic   chk_fail;
   err_e   chk_code;
   logic   chk_crc_flag;
   logic   chk_ready;
   logic   op_inc;
   logic [PRE_W-1:0] pre_cnt;
   logic [TRY_W-1:0] op_cnt;

   assign can_start = (state == S_IDLE) || (state == S_OK) || (state == S_ERR);

   sdinit_counter #(.W(PRE_W)) u_pre_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (can_start && start),
      .inc   ((state == S_PRE) && sd_clk_tick),
      .count (pre_cnt)
   );

   assign op_inc = (state == S_RSP) && rsp_valid && (step == STP_OP)
                   && !chk_fail && !chk_ready;

   sdinit_counter #(.W(TRY_W)) u_op_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (can_start && start),
      .inc   (op_inc),
      .count (op_cnt)
   );

   assign pre_done = (pre_cnt >= PRE_END);
   assign op_last  = (op_cnt >= OP_LAST);

   sdinit_cmd_table #(.CHECK_BYTE(CHECK_BYTE), .OP_ARG(OP_ARG)) u_cmd_table (
      .step  (step),
      .index (cmd_index),
      .arg   (cmd_arg)
   );

   sdinit_rsp_check #(.CHECK_BYTE(CHECK_BYTE), .STRICT_ECHO(STRICT_ECHO)) u_rsp_check (
      .step       (step),
      .payload    (rsp_payload),
      .crc_ok     (rsp_crc_ok),
      .timeout    (rsp_timeout),
      .frame_err  (rsp_frame_err),
      .fail       (chk_fail),
      .fail_code  (chk_code),
      .crc_flag   (chk_crc_flag),
      .card_ready (chk_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         step        <= STP_RST;
         err_q       <= ERR_NONE;
         app_retried <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE, S_OK, S_ERR: begin
               if (start) begin
                  state       <= S_PRE;
                  step        <= STP_RST;
                  err_q       <= ERR_NONE;
                  app_retried <= 1'b0;
               end
            end
            S_PRE: begin
               if (pre_done) state <= S_ISSUE;
            end
            S_ISSUE: begin
               if (cmd_ready) state <= S_SENT;
            end
            S_SENT: begin
               if (cmd_done) begin
                  if (step == STP_RST) begin
                     step  <= STP_IF;
                     state <= S_ISSUE;
                  end else begin
                     state <= S_RSP;
                  end
               end
            end
            S_RSP: begin
               if (rsp_valid) begin
                  if (chk_fail) begin
                     err_q <= chk_code;
                     state <= S_ERR;
                  end else begin
                     unique case (step)
                        STP_IF: begin
                           step  <= STP_APP;
                           state <= S_ISSUE;
                        end
                        STP_APP: begin
                           if (chk_crc_flag && !app_retried)
                              app_retried <= 1'b1;
                           else
                              step <= STP_OP;
                           state <= S_ISSUE;
                        end
                        STP_OP: begin
                           if (chk_ready) begin
                              state <= S_OK;
                           end else if (op_last) begin
                              err_q <= ERR_OP_BUSY;
                              state <= S_ERR;
                           end else begin
                              step        <= STP_APP;
                              app_retried <= 1'b0;
                              state       <= S_ISSUE;
                           end
                        end
                        default: state <= S_ISSUE;
                     endcase
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign preamble  = (state == S_PRE);
   assign cmd_valid = (state == S_ISSUE);
   assign rsp_req   = (state == S_RSP);
   assign done      = (state == S_OK);
   assign error     = (state == S_ERR);
   assign err_code  = err_q;

endmodule

// File: rtl/sdinit_seq_chk.sv
module sdinit_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sd_clk_tick,
   input logic        preamble,
   input logic        done,
   input logic        error,
   input logic [3:0]  err_code,
   input logic        cmd_valid,
   input logic        cmd_ready,
   input logic [5:0]  cmd_index,
   input logic [31:0] cmd_arg,
   input logic        rsp_req
);
   logic [15:0] pre_ticks;
   logic [5:0]  last_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_ticks <= '0;
      else if (!preamble)
         pre_ticks <= '0;
      else if (sd_clk_tick && pre_ticks != 16'hFFFF)
         pre_ticks <= pre_ticks + 16'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         last_acc <= 6'h3F;
      else if (cmd_valid && cmd_ready)
         last_acc <= cmd_index;
   end

   assert_pre_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(preamble) |-> (pre_ticks >= 16'd74));

   assert_no_cmd_in_pre_R1: assert property (@(posedge clk) disable iff (!rst_n)
      preamble |-> !cmd_valid);

   assert_first_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(preamble) |-> (cmd_valid && cmd_index == 6'd0 && cmd_arg == 32'h0));

   assert_op_after_app_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_index == 6'd41) |-> (last_acc == 6'd55));

   assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!error && err_code == 4'd0));

   assert_err_coded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> (err_code != 4'd0));

   assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

   assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && rsp_req));

   assert_end_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> !(cmd_valid || rsp_req || preamble));

endmodule

bind sdinit_seq sdinit_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sd_clk_tick (sd_clk_tick),
   .preamble    (preamble),
   .done        (done),
   .error       (error),
   .err_code    (err_code),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_index   (cmd_index),
   .cmd_arg     (cmd_arg),
   .rsp_req     (rsp_req)
);

// File: tb/sim_sdinit_seq.sv
module sim_sdinit_seq;
   localparam int IDLE_CLKS = 80;
   localparam int MAX_TRIES = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        sd_clk_tick = 1'b0;
   logic        preamble, done, error;
   logic [3:0]  err_code;
   logic        cmd_valid;
   logic        cmd_ready = 1'b0;
   logic [5:0]  cmd_index;
   logic [31:0] cmd_arg;
   logic        cmd_done = 1'b0;
   logic        rsp_req;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_payload = '0;
   logic        rsp_crc_ok = 1'b0;
   logic        rsp_timeout = 1'b0;
   logic        rsp_frame_err = 1'b0;

   sdinit_seq #(.IDLE_CLKS(IDLE_CLKS), .MAX_OP_TRIES(MAX_TRIES)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sd_clk_tick(sd_clk_tick),
      .preamble(preamble), .done(done), .error(error), .err_code(err_code),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
      .cmd_arg(cmd_arg), .cmd_done(cmd_done), .rsp_req(rsp_req),
      .rsp_valid(rsp_valid), .rsp_payload(rsp_payload), .rsp_crc_ok(rsp_crc_ok),
      .rsp_timeout(rsp_timeout), .rsp_frame_err(rsp_frame_err)
   );

   always #10 clk = ~clk;

   int n_checks = 0;
   int n_err    = 0;

   // card model knobs
   int echo_byte;
   int fault_idx;
   int fault_kind;   // 1 timeout, 2 framing, 3 crc
   int app_crc_n;
   int op_busy_n;
   int app_seen;
   int op_seen;
   int pre_ticks;
   int hs_err;
   int n_cmd;
   int          log_idx [64];
   logic [31:0] log_arg [64];
   bit          log_rsp [64];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // card clock strobe, with preamble tick count seen by the design
   initial begin
      forever begin
         repeat (3) @(negedge clk);
         sd_clk_tick = 1'b1;
         #9;
         if (preamble) pre_ticks++;
         @(negedge clk);
         sd_clk_tick = 1'b0;
      end
   end

   // serializer and receiver model
   initial begin
      forever begin
         @(negedge clk);
         if (cmd_valid) begin : serve
            int k;
            logic [5:0]  ix;
            logic [31:0] ag;
            ix = cmd_index;
            ag = cmd_arg;
            repeat (2) @(negedge clk);
            if (!cmd_valid || cmd_index != ix || cmd_arg != ag) hs_err++;
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            k = n_cmd;
            if (k < 64) begin
               log_idx[k] = int'(ix);
               log_arg[k] = ag;
               log_rsp[k] = 1'b0;
            end
            n_cmd++;
            repeat (3) @(negedge clk);
            cmd_done = 1'b1;
            @(negedge clk);
            cmd_done = 1'b0;
            @(negedge clk);
            if (rsp_req) begin
               if (k < 64) log_rsp[k] = 1'b1;
               rsp_crc_ok    = 1'b1;
               rsp_timeout   = 1'b0;
               rsp_frame_err = 1'b0;
               case (ix)
                  6'd8:  rsp_payload = {20'h0, 4'h1, 8'(echo_byte)};
                  6'd55: begin
                     rsp_payload = 32'h0000_0120 | ((app_seen < app_crc_n) ? 32'h0080_0000 : 32'h0);
                     app_seen++;
                  end
                  6'd41: begin
                     rsp_payload = (op_seen >= op_busy_n) ? 32'hC0FF_8000 : 32'h00FF_8000;
                     op_seen++;
                  end
                  default: rsp_payload = 32'h0;
               endcase
               if (int'(ix) == fault_idx) begin
                  if (fault_kind == 1) begin rsp_timeout = 1'b1; rsp_payload = 32'h0; end
                  if (fault_kind == 2) rsp_frame_err = 1'b1;
                  if (fault_kind == 3) rsp_crc_ok = 1'b0;
               end
               rsp_valid = 1'b1;
               @(negedge clk);
               rsp_valid     = 1'b0;
               rsp_timeout   = 1'b0;
               rsp_frame_err = 1'b0;
            end
         end
      end
   end

   task automatic set_knobs();
      echo_byte  = 8'hAA;
      fault_idx  = -1;
      fault_kind = 0;
      app_crc_n  = 0;
      op_busy_n  = 0;
   endtask

   task automatic run_seq();
      int t;
      n_cmd     = 0;
      app_seen  = 0;
      op_seen   = 0;
      pre_ticks = 0;
      hs_err    = 0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!(done || error) && t < 20000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic chk_list(input string tag, input int exp[$]);
      chk(n_cmd == exp.size(), {tag, " command count"}, n_cmd, exp.size());
      for (int i = 0; i < exp.size() && i < n_cmd && i < 64; i++)
         chk(log_idx[i] == exp[i], {tag, " command order"}, log_idx[i], exp[i]);
   endtask

   task automatic t_reset();
      chk(!done && !error && err_code == 0, "R10 reset done/error/code", {done, error, err_code}, 0);
      chk(!cmd_valid && !rsp_req && !preamble, "R10 reset requests", {cmd_valid, rsp_req, preamble}, 0);
   endtask

   task automatic t_nominal();
      set_knobs();
      op_busy_n = 2;
      run_seq();
      chk(pre_ticks == IDLE_CLKS, "R1 idle clock run length", pre_ticks, IDLE_CLKS);
      chk(log_idx[0] == 0 && log_arg[0] == 0, "R2 first command", log_arg[0], 0);
      chk(log_rsp[0] == 1'b0, "R2 no response for index 0", log_rsp[0], 0);
      chk(log_arg[1] == 32'h1AA && log_rsp[1], "R3 interface command argument", log_arg[1], 32'h1AA);
      chk_list("R4 nominal", '{0, 8, 55, 41, 55, 41, 55, 41});
      chk(log_arg[2] == 0 && log_arg[3] == 32'h40FF_8000, "R4 round arguments", log_arg[3], 32'h40FF_8000);
      chk(done && !error && err_code == 0, "R6 ready finishes", {done, error, err_code}, 6'h20);
      chk(hs_err == 0, "R9 command held until accepted", hs_err, 0);
   endtask

   task automatic t_app_retry();
      set_knobs();
      app_crc_n = 1;
      run_seq();
      chk_list("R5 one flagged reply", '{0, 8, 55, 55, 41});
      chk(done, "R5 finishes after reissue", done, 1);
      set_knobs();
      app_crc_n = 2;
      run_seq();
      chk_list("R5 two flagged replies", '{0, 8, 55, 55, 41});
      chk(done, "R5 continues after one reissue", done, 1);
   endtask

   task automatic t_echo_bad();
      set_knobs();
      echo_byte = 8'h55;
      run_seq();
      chk(error && err_code == 3, "R3 wrong echo code", err_code, 3);
      chk_list("R3 stops after index 8", '{0, 8});
   endtask

   task automatic fault_case(input int idx, input int kind, input int exp_code, input string tag);
      set_knobs();
      fault_idx  = idx;
      fault_kind = kind;
      run_seq();
      chk(error && !done && err_code == 4'(exp_code), tag, err_code, exp_code);
   endtask

   task automatic t_faults();
      fault_case(8, 1, 1, "R8 index 8 timeout");
      fault_case(8, 3, 2, "R8 index 8 crc");
      fault_case(55, 2, 4, "R8 index 55 framing");
      fault_case(55, 3, 5, "R8 index 55 crc");
      fault_case(41, 1, 6, "R8 index 41 timeout");
      fault_case(41, 2, 6, "R8 index 41 framing");
   endtask

   task automatic t_op_crc_ignored();
      set_knobs();
      fault_idx  = 41;
      fault_kind = 3;
      run_seq();
      chk(done && !error, "R7 crc flag ignored on index 41", {done, error}, 2);
   endtask

   task automatic t_busy_limit();
      int n41;
      set_knobs();
      op_busy_n = 100;
      run_seq();
      chk(error && err_code == 7, "R6 retry limit code", err_code, 7);
      n41 = 0;
      for (int i = 0; i < n_cmd && i < 64; i++)
         if (log_idx[i] == 41) n41++;
      chk(n41 == MAX_TRIES, "R6 index 41 attempts", n41, MAX_TRIES);
   endtask

   task automatic t_hold_restart();
      set_knobs();
      fault_idx  = 8;
      fault_kind = 1;
      run_seq();
      repeat (50) @(negedge clk);
      chk(error && err_code == 1 && !cmd_valid, "R10 error held", err_code, 1);
      set_knobs();
      run_seq();
      chk(done && !error && err_code == 0, "R10 restart clears error", {done, error, err_code}, 6'h20);
      repeat (50) @(negedge clk);
      chk(done && !cmd_valid && !preamble, "R10 done held", done, 1);
   endtask

   initial begin
      set_knobs();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_nominal();
      t_app_retry();
      t_echo_bad();
      t_faults();
      t_op_crc_ignored();
      t_busy_limit();
      t_hold_restart();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule